// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Request Logic

This block buffers audio samples in both directions between a 32-bit register/DMA data port and the serial side of an audio port. It holds one transmit FIFO and one receive FIFO, each 64 words deep. It reports the fill level of each FIFO. It raises a DMA request and a panic signal for each direction against thresholds that software programs. It also drives the status flags that software polls.

The serial side runs off a slow bit-clock enable (`pcm_tick`), which is derived from the single system clock. Three control actions only take effect after a number of these ticks:

- a FIFO clear;
- the echo of a handshake bit, which software toggles and reads back to confirm that earlier control writes have crossed into the serial side;
- release from standby, which has to settle before the serial side may move data.

In packed mode each 32-bit FIFO word carries two 16-bit samples, one per channel. Underrun and overrun set sticky error flags, and software clears them by writing one.

Top module: `pcmq_core`

## Requirements
- R1: After reset both levels are 0, `tx_empty` is 1, `rx_has_data`, `ready`, `sync_rval`, `tx_err` and `rx_err` are 0.
- R2: Words written with `bus_wr` leave on `ser_tx_sample` in write order, one per accepted take in unpacked mode. A write to a full TX FIFO (level 64) is dropped and the level stays 64.
- R3: Words delivered with `ser_rx_put` appear on `bus_rdata` in arrival order and are removed by `bus_rd`. A put into a full RX FIFO with no pop in that cycle is dropped and sets `rx_err`.
- R4: `tx_dreq` is 1 exactly while the TX level is below `tx_req_lvl`. `tx_panic` is 1 exactly while the TX level is below `tx_panic_lvl`.
- R5: `rx_dreq` is 1 exactly while the RX level is above `rx_req_lvl`. `rx_panic` is 1 exactly while the RX level is above `rx_panic_lvl`.
- R6: `tx_empty` means TX level 0 and `rx_has_data` means RX level non-zero. `tx_need` means TX level at most 32. `rx_need` means RX level at least 32.
- R7: A pulse on `tx_clr` or `rx_clr` empties that FIFO on the second `pcm_tick` edge after the pulse. Before that edge the level is unchanged.
- R8: `sync_rval` takes the value written with `sync_wr`/`sync_wval` only at the second `pcm_tick` edge after the write, and changes at no other time.
- R9: `ready` rises at the fourth `pcm_tick` edge after `stby_rel` goes high, and falls as soon as `stby_rel` is low. While `ready` is 0, serial takes and puts change no level and set no error.
- R10: With `tx_run` (or `rx_run`) at 0, serial takes (or puts) are ignored and the FIFO contents are kept intact.
- R11: An accepted take while the TX FIFO is empty sets `tx_err` and returns zero. The flag stays set until a `tx_err_clr` pulse, and a new underrun in the same cycle as the clear wins.
- R12: With `pack_en` = 1, a TX word gives bits [15:0] on the first take and bits [31:16] on the second, both zero-extended, and is popped on the second take. Two RX puts form one word {second[15:0], first[15:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_tick | input | 1 | One-cycle bit-clock enable |
| stby_rel | input | 1 | 1 = standby released |
| tx_run | input | 1 | TX serial run enable |
| rx_run | input | 1 | RX serial run enable |
| pack_en | input | 1 | Two 16-bit samples per word |
| tx_req_lvl | input | 7 | TX DMA request threshold |
| tx_panic_lvl | input | 7 | TX panic threshold |
| rx_req_lvl | input | 7 | RX DMA request threshold |
| rx_panic_lvl | input | 7 | RX panic threshold |
| bus_wr | input | 1 | Write a word into the TX FIFO |
| bus_wdata | input | 32 | Word written |
| bus_rd | input | 1 | Pop the RX FIFO head |
| bus_rdata | output | 32 | RX FIFO head, 0 when empty |
| tx_clr | input | 1 | Clear pulse for the TX FIFO |
| rx_clr | input | 1 | Clear pulse for the RX FIFO |
| sync_wr | input | 1 | Write the handshake bit |
| sync_wval | input | 1 | Handshake value written |
| sync_rval | output | 1 | Handshake value echoed from the serial side |
| tx_err_clr | input | 1 | Write-one clear of `tx_err` |
| rx_err_clr | input | 1 | Write-one clear of `rx_err` |
| ser_tx_take | input | 1 | Serial side needs a TX sample |
| ser_tx_sample | output | 32 | Sample handed over on a take |
| ser_rx_put | input | 1 | Serial side delivers an RX sample |
| ser_rx_sample | input | 32 | Sample delivered |
| tx_level | output | 7 | TX FIFO fill level |
| rx_level | output | 7 | RX FIFO fill level |
| ready | output | 1 | Standby settling complete |
| tx_empty | output | 1 | TX FIFO empty |
| rx_has_data | output | 1 | RX FIFO not empty |
| tx_need | output | 1 | TX FIFO at most half full |
| rx_need | output | 1 | RX FIFO at least half full |
| tx_dreq | output | 1 | TX DMA request |
| rx_dreq | output | 1 | RX DMA request |
| tx_panic | output | 1 | TX panic |
| rx_panic | output | 1 | RX panic |
| tx_err | output | 1 | Sticky TX underrun |
| rx_err | output | 1 | Sticky RX overrun |

## Verification
A corrupt pointer or level shows up on the very next take or read, either as a word out of order against the scoreboard queue or as a request flag that flips at the wrong count. For that reason the threshold edges are checked one word on each side. An error in a tick counter inside the clear, handshake or standby timers shifts its visible effect by whole ticks. So the level, `sync_rval` and `ready` are sampled after every single tick, where an early or late change is seen at once.

// File: rtl/pcmq_pkg.sv
package pcmq_pkg;
  // Direction index used for per-direction arrays
  localparam int IDX_TX = 0;
  localparam int IDX_RX = 1;
  // Width of one packed sample
  localparam int HALF_W = 16;
endpackage

// File: rtl/pcmq_fifo.sv
module pcmq_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      lvl_d = lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  // Storage carries no reset; its contents are qualified by the level
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign level = lvl_q;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));

  // Without push, pop or flush the contents must stay put (R10)
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !flush) |=> $stable(lvl_q));
endmodule

// File: rtl/pcmq_tick_delay.sv
module pcmq_tick_delay #(
  parameter int NTICK = 2,
  localparam int CW = $clog2(NTICK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  output logic fire
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign fire = busy_q && tick && (cnt_q == CW'(NTICK - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (fire)                busy_d = 1'b0;
    else if (busy_q && tick) cnt_d  = cnt_q + 1'b1;
    if (arm) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // A fire needs a tick in its own cycle (R7)
  assert_fire_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> tick);
endmodule

// File: rtl/pcmq_sync_echo.sv
module pcmq_sync_echo #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wr,
  input  logic wval,
  output logic rd
);
  logic              req_q, req_d;
  logic [STAGES-1:0] sh_q, sh_d;

  assign req_d = wr ? wval : req_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sh_d[g] = tick ? req_q : sh_q[g];
    end else begin : g_next
      assign sh_d[g] = tick ? sh_q[g-1] : sh_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      req_q <= req_d;
      sh_q  <= sh_d;
    end
  end

  assign rd = sh_q[STAGES-1];

  assert_echo_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rd));
endmodule

// File: rtl/pcmq_core.sv
module pcmq_core
  import pcmq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int DW         = 2 * HALF_W,
  parameter int CLR_TICKS  = 2,
  parameter int SYNC_TICKS = 2,
  parameter int STBY_TICKS = 4,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pcm_tick,
  input  logic          stby_rel,
  input  logic          tx_run,
  input  logic          rx_run,
  input  logic          pack_en,
  input  logic [LW-1:0] tx_req_lvl,
  input  logic [LW-1:0] tx_panic_lvl,
  input  logic [LW-1:0] rx_req_lvl,
  input  logic [LW-1:0] rx_panic_lvl,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          tx_clr,
  input  logic          rx_clr,
  input  logic          sync_wr,
  input  logic          sync_wval,
  output logic          sync_rval,
  input  logic          tx_err_clr,
  input  logic          rx_err_clr,
  input  logic          ser_tx_take,
  output logic [DW-1:0] ser_tx_sample,
  input  logic          ser_rx_put,
  input  logic [DW-1:0] ser_rx_sample,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          ready,
  output logic          tx_empty,
  output logic          rx_has_data,
  output logic          tx_need,
  output logic          rx_need,
  output logic          tx_dreq,
  output logic          rx_dreq,
  output logic          tx_panic,
  output logic          rx_panic,
  output logic          tx_err,
  output logic          rx_err
);
  localparam int HW   = DW / 2;
  localparam int SW   = $clog2(STBY_TICKS + 1);
  localparam int HALF = DEPTH / 2;

  // ---------------- clear timers, one per direction ----------------
  logic [1:0] clr_arm, clr_fire;
  assign clr_arm[IDX_TX] = tx_clr;
  assign clr_arm[IDX_RX] = rx_clr;

  for (genvar d = 0; d < 2; d++) begin : g_clr
    pcmq_tick_delay #(.NTICK(CLR_TICKS)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (pcm_tick),
      .arm  (clr_arm[d]),
      .fire (clr_fire[d])
    );
  end

  // ---------------- handshake echo ----------------
  pcmq_sync_echo #(.STAGES(SYNC_TICKS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (pcm_tick),
    .wr   (sync_wr),
    .wval (sync_wval),
    .rd   (sync_rval)
  );

  // ---------------- standby settling ----------------
  logic [SW-1:0] stby_q, stby_d;
  always_comb begin
    stby_d = stby_q;
    if (!stby_rel)                                 stby_d = '0;
    else if (pcm_tick && stby_q < SW'(STBY_TICKS)) stby_d = stby_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stby_q <= '0;
    else        stby_q <= stby_d;
  end
  assign ready = stby_rel && (stby_q == SW'(STBY_TICKS));

  // ---------------- FIFOs ----------------
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic          tx_pop, tx_f_full, tx_f_empty;
  logic          rx_push, rx_f_full, rx_f_empty;

  pcmq_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(clr_fire[IDX_TX]),
    .push (bus_wr),
    .wdata(bus_wdata),
    .pop  (tx_pop),
    .rdata(tx_head),
    .level(tx_level),
    .full (tx_f_full),
    .empty(tx_f_empty)
  );

  pcmq_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(clr_fire[IDX_RX]),
    .push (rx_push),
    .wdata(rx_word),
    .pop  (bus_rd),
    .rdata(rx_head),
    .level(rx_level),
    .full (rx_f_full),
    .empty(rx_f_empty)
  );

  // ---------------- TX serial side ----------------
  logic tx_go, tx_half_q, tx_half_d, tx_uflow, tx_err_q, tx_err_d;
  assign tx_go = ser_tx_take && tx_run && ready;

  always_comb begin
    tx_pop        = 1'b0;
    tx_uflow      = 1'b0;
    tx_half_d     = tx_half_q;
    ser_tx_sample = '0;
    if (tx_go) begin
      if (tx_f_empty) begin
        tx_uflow = 1'b1;
      end else if (!pack_en) begin
        ser_tx_sample = tx_head;
        tx_pop        = 1'b1;
      end else if (!tx_half_q) begin
        ser_tx_sample = {{HW{1'b0}}, tx_head[HW-1:0]};
        tx_half_d     = 1'b1;
      end else begin
        ser_tx_sample = {{HW{1'b0}}, tx_head[DW-1:HW]};
        tx_pop        = 1'b1;
        tx_half_d     = 1'b0;
      end
    end
    if (clr_fire[IDX_TX]) tx_half_d = 1'b0;
    tx_err_d = (tx_err_q && !tx_err_clr) || tx_uflow;
  end

  // ---------------- RX serial side ----------------
  logic          rx_go, rx_half_q, rx_half_d, rx_oflow, rx_err_q, rx_err_d;
  logic [HW-1:0] rx_hold_q, rx_hold_d;
  assign rx_go = ser_rx_put && rx_run && ready;

  always_comb begin
    rx_push   = 1'b0;
    rx_word   = ser_rx_sample;
    rx_half_d = rx_half_q;
    rx_hold_d = rx_hold_q;
    if (rx_go) begin
      if (!pack_en) begin
        rx_push = 1'b1;
      end else if (!rx_half_q) begin
        rx_hold_d = ser_rx_sample[HW-1:0];
        rx_half_d = 1'b1;
      end else begin
        rx_word   = {ser_rx_sample[HW-1:0], rx_hold_q};
        rx_push   = 1'b1;
        rx_half_d = 1'b0;
      end
    end
    if (clr_fire[IDX_RX]) rx_half_d = 1'b0;
    rx_oflow = rx_push && rx_f_full && !bus_rd;
    rx_err_d = (rx_err_q && !rx_err_clr) || rx_oflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_half_q <= 1'b0;
      tx_err_q  <= 1'b0;
      rx_half_q <= 1'b0;
      rx_hold_q <= '0;
      rx_err_q  <= 1'b0;
    end else begin
      tx_half_q <= tx_half_d;
      tx_err_q  <= tx_err_d;
      rx_half_q <= rx_half_d;
      rx_hold_q <= rx_hold_d;
      rx_err_q  <= rx_err_d;
    end
  end

  // ---------------- status and requests ----------------
  assign bus_rdata   = rx_f_empty ? '0 : rx_head;
  assign tx_empty    = tx_f_empty;
  assign rx_has_data = !rx_f_empty;
  assign tx_need     = (tx_level <= LW'(HALF));
  assign rx_need     = (rx_level >= LW'(HALF));
  assign tx_dreq     = (tx_level < tx_req_lvl);
  assign rx_dreq     = (rx_level > rx_req_lvl);
  assign tx_panic    = (tx_level < tx_panic_lvl);
  assign rx_panic    = (rx_level > rx_panic_lvl);
  assign tx_err      = tx_err_q;
  assign rx_err      = rx_err_q;

  // ---------------- assertions ----------------
  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_f_full && bus_wr && !tx_pop && !clr_fire[IDX_TX]) |=> (tx_level == LW'(DEPTH)));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire[IDX_TX] |=> (tx_level == '0));

  assert_ready_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(pcm_tick));

  assert_idle_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !bus_rd && !clr_fire[IDX_RX]) |=> $stable(rx_level));

  assert_run_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_run && !bus_wr && !clr_fire[IDX_TX]) |=> $stable(tx_level));

  assert_uflow_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && tx_empty) |=> tx_err);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !tx_err_clr) |=> tx_err);

  assert_oflow_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_go && !pack_en && rx_f_full && !bus_rd) |=> rx_err);
endmodule

// File: tb/pcmq_core_test.sv
module pcmq_core_test;
  localparam int LW = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pcm_tick, stby_rel, tx_run, rx_run, pack_en;
  logic [LW-1:0] tx_req_lvl, tx_panic_lvl, rx_req_lvl, rx_panic_lvl;
  logic bus_wr, bus_rd, tx_clr, rx_clr, sync_wr, sync_wval, sync_rval;
  logic tx_err_clr, rx_err_clr, ser_tx_take, ser_rx_put;
  logic [31:0] bus_wdata, bus_rdata, ser_tx_sample, ser_rx_sample;
  logic [LW-1:0] tx_level, rx_level;
  logic ready, tx_empty, rx_has_data, tx_need, rx_need;
  logic tx_dreq, rx_dreq, tx_panic, rx_panic, tx_err, rx_err;

  pcmq_core uut (
    .clk(clk), .rst_n(rst_n), .pcm_tick(pcm_tick), .stby_rel(stby_rel),
    .tx_run(tx_run), .rx_run(rx_run), .pack_en(pack_en),
    .tx_req_lvl(tx_req_lvl), .tx_panic_lvl(tx_panic_lvl),
    .rx_req_lvl(rx_req_lvl), .rx_panic_lvl(rx_panic_lvl),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .sync_wr(sync_wr), .sync_wval(sync_wval),
    .sync_rval(sync_rval), .tx_err_clr(tx_err_clr), .rx_err_clr(rx_err_clr),
    .ser_tx_take(ser_tx_take), .ser_tx_sample(ser_tx_sample),
    .ser_rx_put(ser_rx_put), .ser_rx_sample(ser_rx_sample),
    .tx_level(tx_level), .rx_level(rx_level), .ready(ready),
    .tx_empty(tx_empty), .rx_has_data(rx_has_data), .tx_need(tx_need),
    .rx_need(rx_need), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
    .tx_panic(tx_panic), .rx_panic(rx_panic), .tx_err(tx_err), .rx_err(rx_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_tx = 1'b0;
  bit mon_rx = 1'b0;
  string tx_tag = "R2";
  string rx_tag = "R3";
  logic [31:0] exp_tx[$];
  logic [31:0] exp_rx[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares produced words against the queues mid-cycle
  always @(negedge clk) begin
    if (mon_tx && ser_tx_take) begin
      if (exp_tx.size() == 0) chk(tx_tag, ser_tx_sample, 32'hDEAD_0000);
      else chk(tx_tag, ser_tx_sample, exp_tx.pop_front());
    end
    if (mon_rx && bus_rd) begin
      if (exp_rx.size() == 0) chk(rx_tag, bus_rdata, 32'hDEAD_0001);
      else chk(rx_tag, bus_rdata, exp_rx.pop_front());
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    pcm_tick = 0; bus_wr = 0; bus_rd = 0; tx_clr = 0; rx_clr = 0;
    sync_wr = 0; tx_err_clr = 0; rx_err_clr = 0;
    ser_tx_take = 0; ser_rx_put = 0; mon_tx = 0; mon_rx = 0;
  endtask

  task automatic tick();
    pcm_tick = 1; step();
  endtask

  task automatic push_tx(input logic [31:0] w, input bit expect_out);
    bus_wr = 1; bus_wdata = w;
    if (expect_out) exp_tx.push_back(w);
    step();
  endtask

  task automatic take_tx(input bit expect_data);
    ser_tx_take = 1; mon_tx = expect_data; step();
  endtask

  task automatic put_rx(input logic [31:0] w, input bit expect_out);
    ser_rx_put = 1; ser_rx_sample = w;
    if (expect_out) exp_rx.push_back(w);
    step();
  endtask

  task automatic pop_rx();
    bus_rd = 1; mon_rx = 1; step();
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pcm_tick = 0; stby_rel = 0; tx_run = 0; rx_run = 0; pack_en = 0;
    tx_req_lvl = 7'h30; rx_req_lvl = 7'h20; tx_panic_lvl = 7'h10; rx_panic_lvl = 7'h30;
    bus_wr = 0; bus_wdata = 0; bus_rd = 0; tx_clr = 0; rx_clr = 0;
    sync_wr = 0; sync_wval = 0; tx_err_clr = 0; rx_err_clr = 0;
    ser_tx_take = 0; ser_rx_put = 0; ser_rx_sample = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 tx_empty", 32'(tx_empty), 1);
    chk("R1 rx_has_data", 32'(rx_has_data), 0);
    chk("R1 ready", 32'(ready), 0);
    chk("R1 sync_rval", 32'(sync_rval), 0);
    chk("R1 errors", {30'b0, tx_err, rx_err}, 0);

    // R9 standby release
    stby_rel = 1; tx_run = 1; rx_run = 1;
    put_rx(32'h1, 0);
    chk("R9 rx put ignored", 32'(rx_level), 0);
    take_tx(0);
    chk("R9 tx take ignored", 32'(tx_err), 0);
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk("R9 not ready yet", 32'(ready), 0);
    end
    tick();
    chk("R9 ready after 4 ticks", 32'(ready), 1);

    // R4/R6 TX thresholds while filling
    for (int i = 1; i <= 64; i++) begin
      push_tx(32'hA500_0000 + 32'(i), 1);
      if (i == 15) begin
        chk("R4 tx_panic at 15", 32'(tx_panic), 1);
        chk("R4 tx_dreq at 15", 32'(tx_dreq), 1);
      end
      if (i == 16) chk("R4 tx_panic at 16", 32'(tx_panic), 0);
      if (i == 32) chk("R6 tx_need at 32", 32'(tx_need), 1);
      if (i == 33) chk("R6 tx_need at 33", 32'(tx_need), 0);
      if (i == 47) chk("R4 tx_dreq at 47", 32'(tx_dreq), 1);
      if (i == 48) chk("R4 tx_dreq at 48", 32'(tx_dreq), 0);
    end
    push_tx(32'hFFFF_FFFF, 0);
    chk("R2 write to full dropped", 32'(tx_level), 64);

    // R10 run off keeps contents
    tx_run = 0;
    take_tx(0);
    chk("R10 tx level kept", 32'(tx_level), 64);
    chk("R10 no error", 32'(tx_err), 0);
    tx_run = 1;

    // R2 drain in order
    tx_tag = "R2";
    for (int i = 0; i < 64; i++) take_tx(1);
    chk("R6 tx_empty", 32'(tx_empty), 1);

    // R11 underrun
    take_tx(0);
    chk("R11 underrun sets tx_err", 32'(tx_err), 1);
    tx_err_clr = 1; step();
    chk("R11 w1c clears tx_err", 32'(tx_err), 0);
    take_tx(0);
    tx_err_clr = 1; ser_tx_take = 1; step();
    chk("R11 set wins over clear", 32'(tx_err), 1);
    tx_err_clr = 1; step();
    chk("R11 cleared again", 32'(tx_err), 0);

    // R5/R6 RX thresholds, R3 overrun and order
    for (int i = 1; i <= 64; i++) begin
      put_rx(32'h5A00_0000 + 32'(i), 1);
      if (i == 1)  chk("R6 rx_has_data", 32'(rx_has_data), 1);
      if (i == 31) chk("R6 rx_need at 31", 32'(rx_need), 0);
      if (i == 32) begin
        chk("R6 rx_need at 32", 32'(rx_need), 1);
        chk("R5 rx_dreq at 32", 32'(rx_dreq), 0);
      end
      if (i == 33) chk("R5 rx_dreq at 33", 32'(rx_dreq), 1);
      if (i == 48) chk("R5 rx_panic at 48", 32'(rx_panic), 0);
      if (i == 49) chk("R5 rx_panic at 49", 32'(rx_panic), 1);
    end
    chk("R3 no error before overrun", 32'(rx_err), 0);
    put_rx(32'hBAD0_BAD0, 0);
    chk("R3 overrun sets rx_err", 32'(rx_err), 1);
    chk("R3 overrun dropped", 32'(rx_level), 64);
    rx_tag = "R3";
    for (int i = 0; i < 64; i++) pop_rx();
    chk("R6 rx empty", 32'(rx_has_data), 0);
    rx_err_clr = 1; step();
    chk("R3 rx_err cleared", 32'(rx_err), 0);

    // R7 clear latency
    for (int i = 0; i < 5; i++) push_tx(32'hC0 + 32'(i), 0);
    tx_clr = 1; step();
    chk("R7 tx level before ticks", 32'(tx_level), 5);
    tick();
    chk("R7 tx level after 1 tick", 32'(tx_level), 5);
    tick();
    chk("R7 tx cleared after 2 ticks", 32'(tx_level), 0);
    for (int i = 0; i < 3; i++) put_rx(32'hD0 + 32'(i), 0);
    rx_clr = 1; step();
    tick();
    chk("R7 rx level after 1 tick", 32'(rx_level), 3);
    tick();
    chk("R7 rx cleared after 2 ticks", 32'(rx_level), 0);

    // R8 handshake echo
    sync_wr = 1; sync_wval = 1; step();
    chk("R8 echo not yet", 32'(sync_rval), 0);
    tick();
    chk("R8 echo after 1 tick", 32'(sync_rval), 0);
    tick();
    chk("R8 echo after 2 ticks", 32'(sync_rval), 1);
    sync_wr = 1; sync_wval = 0; step();
    tick();
    chk("R8 echo holds 1", 32'(sync_rval), 1);
    tick();
    chk("R8 echo returns 0", 32'(sync_rval), 0);

    // R12 packed mode
    pack_en = 1;
    tx_tag = "R12";
    push_tx(32'hBBBB_AAAA, 0);
    exp_tx.push_back(32'h0000_AAAA);
    exp_tx.push_back(32'h0000_BBBB);
    take_tx(1);
    chk("R12 word kept after first half", 32'(tx_level), 1);
    take_tx(1);
    chk("R12 word popped after second half", 32'(tx_level), 0);
    rx_tag = "R12";
    put_rx(32'h0000_1111, 0);
    chk("R12 rx half held", 32'(rx_level), 0);
    put_rx(32'h0000_2222, 0);
    exp_rx.push_back(32'h2222_1111);
    chk("R12 rx word formed", 32'(rx_level), 1);
    pop_rx();
    step();

    chk("R2 tx queue drained", 32'(exp_tx.size()), 0);
    chk("R3 rx queue drained", 32'(exp_rx.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule